// File: doc/BRIEF.md
# Single-Transfer Wishbone Bus Master

This block sits between a small 32-bit processor core and a Wishbone Classic bus. It lets the core perform exactly one load or one store at a time. The core presents a byte address, an access size (byte, halfword or word), a write flag, a signed/unsigned flag for loads and the store data. The block turns that into one classic single transfer. It drives a word address, byte selects and lane-steered write data. When the transfer ends it returns right-justified, extended read data together with a one-cycle completion pulse.

Accesses that are not naturally aligned never reach the bus. The block reports them back to the core with a one-cycle misalignment flag. After every acknowledged transfer the block parks the bus for one full cycle with CYC and STB low. During that cycle it refuses new work by lowering its ready output. The core therefore only has to hold its request until ready is seen high at a clock edge.

Top module: `wb_single_master`

## Requirements
- R1: After a synchronous reset the bus is idle (CYC, STB and WE low), the done and misalignment outputs are low, and req_ready is high.
- R2: A request is taken only on a clock edge where req_valid and req_ready are both high. On the following cycle CYC and STB rise together, and the word address equals byte address bits [31:2].
- R3: Size encoding on req_size: 0 = byte, 1 = halfword, 2 = word, 3 = treated as word. A byte store places the low data byte on all four lanes and sets only select bit addr[1:0]. A halfword store places the low halfword on both halves and selects 4'b0011 when addr[1] is 0 or 4'b1100 when it is 1. A word access selects 4'b1111. Loads use the same selects.
- R4: While CYC is high and ACK is low, address, write data, selects and WE stay unchanged.
- R5: On a load, the selected lanes of the read data are shifted down to bit 0 and sign-extended when req_signed was 1, zero-extended otherwise. WE is low and the write data bus is zero during a load. rdata is zero whenever done is low.
- R6: done is high for exactly one cycle, the same cycle in which ACK is sampled with CYC high.
- R7: In the cycle after ACK, CYC and STB are low and req_ready is low, so any request held there is not taken. req_ready returns high in the next cycle.
- R8: A halfword request with addr[0] set, or a word request with addr[1:0] nonzero, raises misaligned for one cycle in the cycle after the request. It starts no bus cycle, gives no done pulse, and leaves req_ready high.
- R9: WE during a transfer equals the write flag of the request that started it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Core request present |
| req_addr | input | 32 | Byte address of the access |
| req_size | input | 2 | 0 byte, 1 halfword, 2/3 word |
| req_we | input | 1 | 1 = store, 0 = load |
| req_signed | input | 1 | Sign-extend load result |
| req_wdata | input | 32 | Store data, right-justified |
| req_ready | output | 1 | Block is idle and can take a request |
| done | output | 1 | Transfer completed this cycle |
| rdata | output | 32 | Aligned, extended load result |
| misaligned | output | 1 | Last request was misaligned and dropped |
| wb_adr_o | output | 30 | Word address |
| wb_dat_o | output | 32 | Write data |
| wb_dat_i | input | 32 | Read data |
| wb_sel_o | output | 4 | Byte lane selects |
| wb_cyc_o | output | 1 | Cycle valid |
| wb_stb_o | output | 1 | Strobe |
| wb_we_o | output | 1 | Write enable |
| wb_ack_i | input | 1 | Slave acknowledge |

## Verification
A controller stuck in or skipping the post-acknowledge idle state is visible at once. CYC would then stay high, or req_ready would stay high, in the cycle right after ACK. A corrupted captured field shows as a wrong address, wrong select or drifting write data in the first cycle of the transfer, or in any wait cycle before ACK. A wrong stored offset or size only surfaces on the ACK cycle, as a wrongly shifted or wrongly extended rdata. Each load pattern is therefore checked in that cycle.

// File: rtl/wbm_pkg.sv
package wbm_pkg;
   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2,
      SZ_RSVD = 2'd3
   } size_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_BUSY = 2'd1,
      ST_GAP  = 2'd2
   } mst_state_e;
endpackage

// File: rtl/wbm_lane_steer.sv
module wbm_lane_steer
   import wbm_pkg::*;
#(
   parameter int DATA_W = 32,
   localparam int LANES = DATA_W / 8,
   localparam int OFF_W = $clog2(LANES)
) (
   input  size_e              size,
   input  logic [OFF_W-1:0]   off,
   input  logic [DATA_W-1:0]  wdata,
   output logic [LANES-1:0]   sel,
   output logic [DATA_W-1:0]  lane_data
);
   for (genvar i = 0; i < LANES; i++) begin : g_lane
      logic       sel_b;
      logic [7:0] byte_b;
      always_comb begin
         unique case (size)
            SZ_BYTE: begin
               sel_b  = (off == OFF_W'(i));
               byte_b = wdata[7:0];
            end
            SZ_HALF: begin
               sel_b  = (off[OFF_W-1:1] == (OFF_W-1)'(i >> 1));
               byte_b = wdata[8*(i%2) +: 8];
            end
            default: begin
               sel_b  = 1'b1;
               byte_b = wdata[8*i +: 8];
            end
         endcase
      end
      assign sel[i]            = sel_b;
      assign lane_data[8*i +: 8] = byte_b;
   end
endmodule

// File: rtl/wbm_load_align.sv
module wbm_load_align
   import wbm_pkg::*;
#(
   parameter int DATA_W = 32,
   localparam int LANES = DATA_W / 8,
   localparam int OFF_W = $clog2(LANES)
) (
   input  size_e              size,
   input  logic [OFF_W-1:0]   off,
   input  logic               sgn,
   input  logic [DATA_W-1:0]  bus_data,
   output logic [DATA_W-1:0]  value
);
   logic [DATA_W-1:0] shifted;

   assign shifted = bus_data >> {off, 3'b000};

   always_comb begin
      unique case (size)
         SZ_BYTE: value = {{(DATA_W-8){sgn & shifted[7]}}, shifted[7:0]};
         SZ_HALF: value = {{(DATA_W-16){sgn & shifted[15]}}, shifted[15:0]};
         default: value = shifted;
      endcase
   end
endmodule

// File: rtl/wbm_ctrl.sv
module wbm_ctrl
   import wbm_pkg::*;
(
   input  logic clk,
   input  logic rst,
   input  logic req_valid,
   input  logic bad_align,
   input  logic ack,
   output logic ready,
   output logic accept,
   output logic busy,
   output logic done,
   output logic mis_pulse
);
   mst_state_e state_q;

   assign ready  = (state_q == ST_IDLE);
   assign busy   = (state_q == ST_BUSY);
   assign accept = ready & req_valid & ~bad_align;
   assign done   = busy & ack;

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q   <= ST_IDLE;
         mis_pulse <= 1'b0;
      end else begin
         mis_pulse <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (req_valid) begin
                  if (bad_align) mis_pulse <= 1'b1;
                  else           state_q   <= ST_BUSY;
               end
            end
            ST_BUSY: if (ack) state_q <= ST_GAP;
            default: state_q <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/wb_single_master.sv
module wb_single_master
   import wbm_pkg::*;
#(
   parameter int ADDR_W         = 32,
   parameter int DATA_W         = 32,
   parameter bit MISALIGN_CHECK = 1'b1,
   localparam int LANES  = DATA_W / 8,
   localparam int OFF_W  = $clog2(LANES),
   localparam int WADR_W = ADDR_W - OFF_W
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [1:0]        req_size,
   input  logic              req_we,
   input  logic              req_signed,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              req_ready,
   output logic              done,
   output logic [DATA_W-1:0] rdata,
   output logic              misaligned,
   output logic [WADR_W-1:0] wb_adr_o,
   output logic [DATA_W-1:0] wb_dat_o,
   input  logic [DATA_W-1:0] wb_dat_i,
   output logic [LANES-1:0]  wb_sel_o,
   output logic              wb_cyc_o,
   output logic              wb_stb_o,
   output logic              wb_we_o,
   input  logic              wb_ack_i
);
   if (DATA_W != 32) begin : g_bad_width
      $error("wb_single_master: DATA_W must be 32");
   end
   if (ADDR_W <= OFF_W) begin : g_bad_addr
      $error("wb_single_master: ADDR_W too small");
   end

   size_e             req_sz;
   logic [OFF_W-1:0]  req_off;
   logic              bad_align;
   logic              accept;
   logic              busy;
   logic [LANES-1:0]  sel_n;
   logic [DATA_W-1:0] steer_n;
   logic [DATA_W-1:0] aligned;

   size_e             sz_q;
   logic [OFF_W-1:0]  off_q;
   logic              sgn_q;

   assign req_sz  = size_e'(req_size);
   assign req_off = req_addr[OFF_W-1:0];

   if (MISALIGN_CHECK) begin : g_align_chk
      always_comb begin
         unique case (req_sz)
            SZ_BYTE: bad_align = 1'b0;
            SZ_HALF: bad_align = req_off[0];
            default: bad_align = |req_off;
         endcase
      end
   end else begin : g_align_off
      assign bad_align = 1'b0;
   end

   wbm_ctrl u_ctrl (
      .clk       (clk),
      .rst       (rst),
      .req_valid (req_valid),
      .bad_align (bad_align),
      .ack       (wb_ack_i),
      .ready     (req_ready),
      .accept    (accept),
      .busy      (busy),
      .done      (done),
      .mis_pulse (misaligned)
   );

   wbm_lane_steer #(.DATA_W(DATA_W)) u_steer (
      .size      (req_sz),
      .off       (req_off),
      .wdata     (req_wdata),
      .sel       (sel_n),
      .lane_data (steer_n)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         wb_adr_o <= '0;
         wb_dat_o <= '0;
         wb_sel_o <= '0;
         wb_we_o  <= 1'b0;
         sz_q     <= SZ_WORD;
         off_q    <= '0;
         sgn_q    <= 1'b0;
      end else if (accept) begin
         wb_adr_o <= req_addr[ADDR_W-1:OFF_W];
         wb_dat_o <= req_we ? steer_n : '0;
         wb_sel_o <= sel_n;
         wb_we_o  <= req_we;
         sz_q     <= req_sz;
         off_q    <= req_off;
         sgn_q    <= req_signed;
      end else if (done) begin
         wb_we_o  <= 1'b0;
      end
   end

   assign wb_cyc_o = busy;
   assign wb_stb_o = busy;

   wbm_load_align #(.DATA_W(DATA_W)) u_align (
      .size     (sz_q),
      .off      (off_q),
      .sgn      (sgn_q),
      .bus_data (wb_dat_i),
      .value    (aligned)
   );

   assign rdata = done ? aligned : '0;
endmodule

// File: rtl/wbm_checker.sv
module wbm_checker #(
   parameter int DATA_W = 32,
   parameter int WADR_W = 30,
   localparam int LANES = DATA_W / 8
) (
   input logic              clk,
   input logic              rst,
   input logic              req_ready,
   input logic              done,
   input logic [DATA_W-1:0] rdata,
   input logic              misaligned,
   input logic [WADR_W-1:0] wb_adr_o,
   input logic [DATA_W-1:0] wb_dat_o,
   input logic [LANES-1:0]  wb_sel_o,
   input logic              wb_cyc_o,
   input logic              wb_stb_o,
   input logic              wb_we_o,
   input logic              wb_ack_i
);
   p_reset_idle_r1: assert property (@(posedge clk)
      rst |=> (!wb_cyc_o && !wb_stb_o && req_ready && !done));

   p_hold_r4: assert property (@(posedge clk) disable iff (rst)
      (wb_cyc_o && !wb_ack_i) |=> (wb_cyc_o && $stable(wb_adr_o) && $stable(wb_dat_o)
                                   && $stable(wb_sel_o) && $stable(wb_we_o)));

   p_sel_shape_r3: assert property (@(posedge clk) disable iff (rst)
      wb_cyc_o |-> ($countones(wb_sel_o) == 1 || $countones(wb_sel_o) == 2
                    || $countones(wb_sel_o) == 4));

   p_rdata_quiet_r5: assert property (@(posedge clk) disable iff (rst)
      !done |-> (rdata == '0));

   p_done_on_ack_r6: assert property (@(posedge clk) disable iff (rst)
      done |-> (wb_cyc_o && wb_ack_i));

   p_ack_gives_done_r6: assert property (@(posedge clk) disable iff (rst)
      (wb_cyc_o && wb_ack_i) |-> done);

   p_done_single_r6: assert property (@(posedge clk) disable iff (rst)
      done |=> !done);

   p_gap_r7: assert property (@(posedge clk) disable iff (rst)
      (wb_cyc_o && wb_ack_i) |=> (!wb_cyc_o && !wb_stb_o && !req_ready));

   p_busy_not_ready_r7: assert property (@(posedge clk) disable iff (rst)
      wb_cyc_o |-> !req_ready);

   p_misalign_quiet_r8: assert property (@(posedge clk) disable iff (rst)
      misaligned |-> (!wb_cyc_o && !done && req_ready));
endmodule

bind wb_single_master wbm_checker #(.DATA_W(DATA_W), .WADR_W(WADR_W)) u_wbm_checker (
   .clk        (clk),
   .rst        (rst),
   .req_ready  (req_ready),
   .done       (done),
   .rdata      (rdata),
   .misaligned (misaligned),
   .wb_adr_o   (wb_adr_o),
   .wb_dat_o   (wb_dat_o),
   .wb_sel_o   (wb_sel_o),
   .wb_cyc_o   (wb_cyc_o),
   .wb_stb_o   (wb_stb_o),
   .wb_we_o    (wb_we_o),
   .wb_ack_i   (wb_ack_i)
);

// File: tb/tb_wb_single_master.sv
module tb_wb_single_master;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        req_valid = 1'b0;
   logic [31:0] req_addr = '0;
   logic [1:0]  req_size = '0;
   logic        req_we = 1'b0;
   logic        req_signed = 1'b0;
   logic [31:0] req_wdata = '0;
   logic        req_ready, done, misaligned;
   logic [31:0] rdata;
   logic [29:0] wb_adr_o;
   logic [31:0] wb_dat_o;
   logic [31:0] wb_dat_i = '0;
   logic [3:0]  wb_sel_o;
   logic        wb_cyc_o, wb_stb_o, wb_we_o;
   logic        wb_ack_i = 1'b0;

   int n_chk  = 0;
   int n_fail = 0;
   bit ended  = 1'b0;

   always #10 clk = ~clk;

   wb_single_master dut (
      .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
      .req_size(req_size), .req_we(req_we), .req_signed(req_signed),
      .req_wdata(req_wdata), .req_ready(req_ready), .done(done), .rdata(rdata),
      .misaligned(misaligned), .wb_adr_o(wb_adr_o), .wb_dat_o(wb_dat_o),
      .wb_dat_i(wb_dat_i), .wb_sel_o(wb_sel_o), .wb_cyc_o(wb_cyc_o),
      .wb_stb_o(wb_stb_o), .wb_we_o(wb_we_o), .wb_ack_i(wb_ack_i)
   );

   task automatic chk(input string req, input string what, input logic [31:0] act,
                      input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic drive_req(input logic [31:0] a, input logic [1:0] sz, input logic we,
                            input logic sg, input logic [31:0] wd);
      req_valid = 1'b1; req_addr = a; req_size = sz; req_we = we;
      req_signed = sg; req_wdata = wd;
   endtask

   // One complete transfer with a slave that waits waitn cycles before ACK
   task automatic access(input string tag, input logic [31:0] a, input logic [1:0] sz,
                         input logic we, input logic sg, input logic [31:0] wd,
                         input int waitn, input logic [29:0] e_adr, input logic [3:0] e_sel,
                         input logic [31:0] e_dat, input logic [31:0] din,
                         input logic [31:0] e_rd);
      @(negedge clk);
      chk("R2", {tag, " ready before"}, 32'(req_ready), 32'd1);
      drive_req(a, sz, we, sg, wd);
      @(negedge clk);
      req_valid = 1'b0;
      #1;
      chk("R2", {tag, " cyc"}, 32'(wb_cyc_o), 32'd1);
      chk("R2", {tag, " stb"}, 32'(wb_stb_o), 32'd1);
      chk("R2", {tag, " adr"}, 32'(wb_adr_o), 32'(e_adr));
      chk("R3", {tag, " sel"}, 32'(wb_sel_o), 32'(e_sel));
      chk(we ? "R3" : "R5", {tag, " dat_o"}, wb_dat_o, e_dat);
      chk("R9", {tag, " we"}, 32'(wb_we_o), 32'(we));
      for (int k = 0; k < waitn; k++) begin
         @(negedge clk);
         #1;
         chk("R4", {tag, " hold cyc"}, 32'(wb_cyc_o), 32'd1);
         chk("R4", {tag, " hold adr"}, 32'(wb_adr_o), 32'(e_adr));
         chk("R4", {tag, " hold dat"}, wb_dat_o, e_dat);
         chk("R6", {tag, " no early done"}, 32'(done), 32'd0);
      end
      wb_ack_i = 1'b1;
      wb_dat_i = din;
      #1;
      chk("R6", {tag, " done on ack"}, 32'(done), 32'd1);
      if (!we) chk("R5", {tag, " rdata"}, rdata, e_rd);
      @(negedge clk);
      wb_ack_i = 1'b0;
      wb_dat_i = 32'hFFFF_FFFF;
      #1;
      chk("R7", {tag, " cyc low after ack"}, 32'(wb_cyc_o), 32'd0);
      chk("R7", {tag, " ready low in gap"}, 32'(req_ready), 32'd0);
      chk("R6", {tag, " done single"}, 32'(done), 32'd0);
      chk("R5", {tag, " rdata idle"}, rdata, 32'd0);
      @(negedge clk);
      #1;
      chk("R7", {tag, " ready back"}, 32'(req_ready), 32'd1);
   endtask

   task automatic misalign(input string tag, input logic [31:0] a, input logic [1:0] sz);
      @(negedge clk);
      drive_req(a, sz, 1'b1, 1'b0, 32'h1111_2222);
      @(negedge clk);
      req_valid = 1'b0;
      #1;
      chk("R8", {tag, " flag"}, 32'(misaligned), 32'd1);
      chk("R8", {tag, " no cyc"}, 32'(wb_cyc_o), 32'd0);
      chk("R8", {tag, " ready"}, 32'(req_ready), 32'd1);
      @(negedge clk);
      #1;
      chk("R8", {tag, " pulse ends"}, 32'(misaligned), 32'd0);
      chk("R8", {tag, " still no cyc"}, 32'(wb_cyc_o), 32'd0);
      chk("R8", {tag, " no done"}, 32'(done), 32'd0);
   endtask

   task automatic gap_holdoff();
      @(negedge clk);
      drive_req(32'h0000_0040, 2'd2, 1'b0, 1'b0, '0);
      @(negedge clk);
      req_valid = 1'b0;
      wb_ack_i = 1'b1;
      wb_dat_i = 32'h0BAD_F00D;
      @(negedge clk);
      wb_ack_i = 1'b0;
      drive_req(32'h0000_0008, 2'd0, 1'b1, 1'b0, 32'h0000_005A);
      #1;
      chk("R7", "gap: ready low", 32'(req_ready), 32'd0);
      @(negedge clk);
      #1;
      chk("R7", "gap: request not taken", 32'(wb_cyc_o), 32'd0);
      chk("R7", "gap: ready back", 32'(req_ready), 32'd1);
      @(negedge clk);
      req_valid = 1'b0;
      #1;
      chk("R2", "gap: later start", 32'(wb_cyc_o), 32'd1);
      chk("R2", "gap: adr", 32'(wb_adr_o), 32'd2);
      chk("R3", "gap: sel", 32'(wb_sel_o), 32'h1);
      chk("R3", "gap: dat", wb_dat_o, 32'h5A5A_5A5A);
      wb_ack_i = 1'b1;
      @(negedge clk);
      wb_ack_i = 1'b0;
      @(negedge clk);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      #1;
      chk("R1", "reset cyc", 32'(wb_cyc_o), 32'd0);
      chk("R1", "reset stb", 32'(wb_stb_o), 32'd0);
      chk("R1", "reset we", 32'(wb_we_o), 32'd0);
      chk("R1", "reset done", 32'(done), 32'd0);
      chk("R1", "reset misaligned", 32'(misaligned), 32'd0);
      chk("R1", "reset ready", 32'(req_ready), 32'd1);

      access("word st", 32'h0000_0100, 2'd2, 1'b1, 1'b0, 32'hDEAD_BEEF, 2,
             30'h40, 4'hF, 32'hDEAD_BEEF, '0, '0);
      access("byte st hi", 32'h0000_0203, 2'd0, 1'b1, 1'b0, 32'h1234_56A5, 1,
             30'h80, 4'h8, 32'hA5A5_A5A5, '0, '0);
      access("byte st lo", 32'h0000_0010, 2'd0, 1'b1, 1'b0, 32'h0000_0077, 0,
             30'h4, 4'h1, 32'h7777_7777, '0, '0);
      access("half st hi", 32'h0000_0012, 2'd1, 1'b1, 1'b0, 32'hFFFF_1234, 0,
             30'h4, 4'hC, 32'h1234_1234, '0, '0);
      access("size3 st", 32'hFFFF_FFFC, 2'd3, 1'b1, 1'b0, 32'h0102_0304, 0,
             30'h3FFF_FFFF, 4'hF, 32'h0102_0304, '0, '0);
      access("byte ld s", 32'h0000_0001, 2'd0, 1'b0, 1'b1, '0, 1,
             30'h0, 4'h2, '0, 32'h1122_8033, 32'hFFFF_FF80);
      access("byte ld u", 32'h0000_0001, 2'd0, 1'b0, 1'b0, '0, 0,
             30'h0, 4'h2, '0, 32'h1122_8033, 32'h0000_0080);
      access("half ld s", 32'h0000_0022, 2'd1, 1'b0, 1'b1, '0, 3,
             30'h8, 4'hC, '0, 32'h9ABC_0000, 32'hFFFF_9ABC);
      access("half ld u", 32'h0000_0022, 2'd1, 1'b0, 1'b0, '0, 0,
             30'h8, 4'hC, '0, 32'h9ABC_0000, 32'h0000_9ABC);
      access("half ld pos", 32'h0000_0020, 2'd1, 1'b0, 1'b1, '0, 0,
             30'h8, 4'h3, '0, 32'hFFFF_7FFF, 32'h0000_7FFF);
      access("word ld", 32'h0000_0004, 2'd2, 1'b0, 1'b1, '0, 0,
             30'h1, 4'hF, '0, 32'hCAFE_F00D, 32'hCAFE_F00D);

      misalign("word mis", 32'h0000_0002, 2'd2);
      misalign("half mis", 32'h0000_0003, 2'd1);
      gap_holdoff();

      if (!ended) begin
         ended = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!ended) begin
         ended = 1'b1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
         $finish;
      end
   end
endmodule